// File: doc/BRIEF.md
# Key-Protected DRAM Controller Register Bank

This block is the software-visible register window of a DRAM controller. It holds 32-bit control, status and calibration words in a 4 KiB window that is reached through a simple single-cycle request port. A lock word at the bottom of the window guards most of the bank. After reset the bank is soft-locked. Writing the opening key opens it. Writing the sealing key seals it until the next reset. Any other value written to the lock word puts the bank back into the soft-locked state.

Several words never take raw write data. The configuration word always carries its hardware-fixed fields. These are a version number, an aperture code and a DRAM size code derived from the `RAM_MIB` parameter. The PHY status word always reports "not busy" and "PLL locked". The self-test control word always reports "finished, no failure". A short list of test and scratch words sits outside the protection and accepts writes in any lock state.

The request port has no back-pressure and accepts one request every cycle. A read answers with `rsp_valid` and `rsp_rdata` exactly one cycle later. A write produces no response.

Top module: `dram_cfg_regbank`

## Requirements
- R1: A write to byte offset 0x000 stores 0x00000001 when the data is 0xFC600309, stores 0x00000010 when the data is 0xDEADDEAD, and stores 0x00000000 for any other value. Reading offset 0x000 returns the stored value. The stored value after reset is 0x00000000, which is the soft-locked state.
- R2: While the lock word reads 0x10 (sealed), every write to a protected word is dropped, including writes to the lock word itself. Only reset leaves this state.
- R3: While the lock word reads 0x00 (soft-locked), writes to protected words other than the lock word are dropped.
- R4: The words at byte offsets 0x050, 0x06C, 0x074, 0x078, 0x07C, 0x088, 0x08C and 0x0B4 store the written data unchanged in every lock state.
- R5: A write to the configuration word at 0x004 takes the written data in every bit except bits 31:28, 19, 18:14, 6, 3:2 and 1:0. Those bits take their fixed values.
- R6: The fixed configuration fields are: version 3 in bits 31:28, aperture code 3 in bits 3:2, and zero in bits 19, 18:14 and 6. Bits 1:0 hold a size code of 0, 1, 2 or 3 for `RAM_MIB` of 256, 512, 1024 or 2048.
- R7: An accepted write to the PHY status word at 0x060 stores bit 0 as 0 and bit 4 as 1. All other bits take the written data.
- R8: An accepted write to the test control word at 0x070 stores bit 12 as 1 and bit 13 as 0. All other bits take the written data.
- R9: After reset every word reads zero, with these exceptions: the configuration word holds its fixed fields, word index 0x100 (offset 0x400) reads 0x2, offsets 0x468 and 0x47C read 0xFF, and offset 0x450 reads 0x0FFFFFFF.
- R10: A read request (`req_valid` high, `req_write` low) raises `rsp_valid` on the next cycle, with `rsp_rdata` holding the addressed word. Write requests and idle cycles leave `rsp_valid` low.
- R11: A word index (byte address bits 11:2) at or above `NUM_WORDS` reads zero, and writes to it have no effect.
- R12: While the bank is open (lock word 0x01), a write to any other protected word stores the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address; bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | 32 | Read data |

## Verification
The whole 1024-word window is swept with reads right after reset. This separates the fixed and PHY reset words from the zero-reset words and from the unimplemented range. A write sweep with an index-dependent pattern is then run in each lock state: soft-locked, open and sealed. Each sweep is followed by a read sweep. This separates dropped writes from the always-open list, and shows the per-word coercion of the configuration, status and test words. Directed writes of all-ones and all-zeros to the configuration word expose each fixed field. Key writes with near-miss values, and attempts to reopen a sealed bank, separate the three lock encodings.

// File: rtl/dram_cfg_pkg.sv
package dram_cfg_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;

  typedef enum logic [1:0] {
    LK_SOFT = 2'd0,
    LK_OPEN = 2'd1,
    LK_HARD = 2'd2
  } lock_e;

  localparam logic [DATA_W-1:0] KEY_OPEN = 32'hFC60_0309;
  localparam logic [DATA_W-1:0] KEY_SEAL = 32'hDEAD_DEAD;

  localparam logic [DATA_W-1:0] LOCK_WORD_OPEN = 32'h0000_0001;
  localparam logic [DATA_W-1:0] LOCK_WORD_SEAL = 32'h0000_0010;
  localparam logic [DATA_W-1:0] LOCK_WORD_SOFT = 32'h0000_0000;

  // word indices whose handling depends on position
  localparam logic [IDX_W-1:0] IX_LOCK  = 10'h000;
  localparam logic [IDX_W-1:0] IX_CONF  = 10'h001;
  localparam logic [IDX_W-1:0] IX_PHYST = 10'h018;
  localparam logic [IDX_W-1:0] IX_TEST  = 10'h01C;
  localparam logic [IDX_W-1:0] IX_PHY0  = 10'h100;
  localparam logic [IDX_W-1:0] IX_EYE_A = 10'h11A;
  localparam logic [IDX_W-1:0] IX_EYE_B = 10'h11F;
  localparam logic [IDX_W-1:0] IX_EYE_C = 10'h114;

  // configuration bits replaced by hardware values on every write
  localparam logic [DATA_W-1:0] CONF_HW_MASK = 32'hF00F_C04F;

  localparam int PHYST_BUSY_BIT = 0;
  localparam int PHYST_PLL_BIT  = 4;
  localparam int TEST_DONE_BIT  = 12;
  localparam int TEST_FAIL_BIT  = 13;

  function automatic logic [1:0] size_code(input int ram_mib);
    case (ram_mib)
      256:     return 2'd0;
      512:     return 2'd1;
      1024:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] conf_hw_bits(input int ver, input int aper,
                                                     input int ram_mib);
    logic [DATA_W-1:0] v;
    v        = '0;
    v[31:28] = ver[3:0];
    v[3:2]   = aper[1:0];
    v[1:0]   = size_code(ram_mib);
    return v;
  endfunction

  function automatic logic is_open_word(input logic [IDX_W-1:0] ix);
    case (ix)
      10'h014, 10'h01B, 10'h01D, 10'h01E,
      10'h01F, 10'h022, 10'h023, 10'h02D: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reset_word(input int ix,
                                                   input logic [DATA_W-1:0] conf_rst);
    if (ix == int'(IX_CONF))  return conf_rst;
    if (ix == int'(IX_PHY0))  return 32'h0000_0002;
    if (ix == int'(IX_EYE_A)) return 32'h0000_00FF;
    if (ix == int'(IX_EYE_B)) return 32'h0000_00FF;
    if (ix == int'(IX_EYE_C)) return 32'h0FFF_FFFF;
    return '0;
  endfunction

endpackage

// File: rtl/dram_cfg_lock.sv
module dram_cfg_lock
  import dram_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [DATA_W-1:0] key_data,
  output lock_e             lock_state,
  output logic [DATA_W-1:0] lock_word
);

  lock_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LK_SOFT;
    end else if (key_we && state_q != LK_HARD) begin
      if (key_data == KEY_OPEN)      state_q <= LK_OPEN;
      else if (key_data == KEY_SEAL) state_q <= LK_HARD;
      else                           state_q <= LK_SOFT;
    end
  end

  always_comb begin
    case (state_q)
      LK_OPEN: lock_word = LOCK_WORD_OPEN;
      LK_HARD: lock_word = LOCK_WORD_SEAL;
      default: lock_word = LOCK_WORD_SOFT;
    endcase
  end

  assign lock_state = state_q;

  // R1: opening key from a non-sealed state yields the open encoding
  a_r1_open_key: assert property (@(posedge clk) disable iff (!rst_n)
    key_we && key_data == KEY_OPEN && state_q != LK_HARD |=> lock_word == LOCK_WORD_OPEN);

  // R2: sealed state persists until reset
  a_r2_seal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == LK_HARD |=> state_q == LK_HARD);

endmodule

// File: rtl/dram_cfg_shaper.sv
module dram_cfg_shaper
  import dram_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] CONF_HW = '0
) (
  input  logic [IDX_W-1:0]  ix,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_comb begin
    dout = din;
    case (ix)
      IX_CONF: dout = (din & ~CONF_HW_MASK) | CONF_HW;
      IX_PHYST: begin
        dout[PHYST_BUSY_BIT] = 1'b0;
        dout[PHYST_PLL_BIT]  = 1'b1;
      end
      IX_TEST: begin
        dout[TEST_DONE_BIT] = 1'b1;
        dout[TEST_FAIL_BIT] = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dram_cfg_store.sv
module dram_cfg_store
  import dram_cfg_pkg::*;
#(
  parameter int                NUM_WORDS = 320,
  parameter logic [DATA_W-1:0] CONF_HW   = '0,
  localparam int               SIX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SIX_W-1:0]  wix,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SIX_W-1:0]  rix,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [DATA_W-1:0] RST_V = reset_word(w, CONF_HW);
    always_ff @(posedge clk) begin
      if (!rst_n)                            mem[w] <= RST_V;
      else if (we && wix == SIX_W'(w))       mem[w] <= wdata;
    end
  end

  assign rdata = (int'(rix) < NUM_WORDS) ? mem[rix] : '0;

  // R5/R6: hardware-owned configuration bits always hold their fixed values
  a_r6_conf_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem[IX_CONF] & CONF_HW_MASK) == CONF_HW);

  // R7: a stored status word never reports busy and always reports PLL lock
  a_r7_phy_status: assert property (@(posedge clk) disable iff (!rst_n)
    we && wix == SIX_W'(IX_PHYST) |=> !mem[IX_PHYST][PHYST_BUSY_BIT] && mem[IX_PHYST][PHYST_PLL_BIT]);

  // R8: a stored test control word is finished and not failed
  a_r8_test_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    we && wix == SIX_W'(IX_TEST) |=> mem[IX_TEST][TEST_DONE_BIT] && !mem[IX_TEST][TEST_FAIL_BIT]);

endmodule

// File: rtl/dram_cfg_regbank.sv
module dram_cfg_regbank
  import dram_cfg_pkg::*;
#(
  parameter int NUM_WORDS = 320,
  parameter int RAM_MIB   = 512,
  parameter int HW_VER    = 3,
  parameter int APERTURE  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int                SIX_W   = $clog2(NUM_WORDS);
  localparam logic [IDX_W:0]    LIMIT   = (IDX_W+1)'(NUM_WORDS);
  localparam logic [DATA_W-1:0] CONF_HW = conf_hw_bits(HW_VER, APERTURE, RAM_MIB);

  logic [IDX_W-1:0]  ix;
  logic              in_rng, wr_req, rd_req, bypass;
  logic              key_we, store_we;
  lock_e             lock_state;
  logic [DATA_W-1:0] lock_word, shaped, store_wdata, store_rdata;

  assign ix     = req_addr[ADDR_W-1:2];
  assign in_rng = {1'b0, ix} < LIMIT;
  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;
  assign bypass = is_open_word(ix);

  assign key_we   = wr_req && ix == IX_LOCK;
  assign store_we = wr_req && in_rng && ix != IX_LOCK &&
                    (bypass || lock_state == LK_OPEN);
  assign store_wdata = bypass ? req_wdata : shaped;

  dram_cfg_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_we     (key_we),
    .key_data   (req_wdata),
    .lock_state (lock_state),
    .lock_word  (lock_word)
  );

  dram_cfg_shaper #(.CONF_HW(CONF_HW)) u_shaper (
    .ix   (ix),
    .din  (req_wdata),
    .dout (shaped)
  );

  dram_cfg_store #(.NUM_WORDS(NUM_WORDS), .CONF_HW(CONF_HW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_we),
    .wix   (ix[SIX_W-1:0]),
    .wdata (store_wdata),
    .rix   (ix[SIX_W-1:0]),
    .rdata (store_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (!rd_req || !in_rng) rsp_rdata <= '0;
      else if (ix == IX_LOCK)  rsp_rdata <= lock_word;
      else                     rsp_rdata <= store_rdata;
    end
  end

  // R10: a read request is answered on the next cycle, nothing else answers
  a_r10_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);

  // R11: reads beyond the implemented array return zero
  a_r11_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !in_rng |=> rsp_rdata == '0);

  // R3: soft lock blocks every protected word except the lock word
  a_r3_soft_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state == LK_SOFT && !bypass |-> !store_we);

endmodule

// File: tb/dram_cfg_regbank_tb.sv
module dram_cfg_regbank_tb_top;
  import dram_cfg_pkg::*;

  localparam int  CLK_PERIOD = 10;
  localparam int  NW   = 320;
  localparam int  RMIB = 512;
  localparam int  WIN  = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] exp_mem [WIN];
  int          exp_lock;   // 0 soft, 1 open, 2 sealed

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cfg_regbank #(.NUM_WORDS(NW), .RAM_MIB(RMIB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  function automatic logic [31:0] conf_fixed();
    int code = 0;
    int m = 256;
    while (m < RMIB) begin m = m * 2; code++; end
    return (32'd3 << 28) | (32'd3 << 2) | 32'(code);
  endfunction

  function automatic bit open_list(int i);
    return i == 'h50/4 || i == 'h6C/4 || i == 'h74/4 || i == 'h78/4 ||
           i == 'h7C/4 || i == 'h88/4 || i == 'h8C/4 || i == 'hB4/4;
  endfunction

  function automatic logic [31:0] lock_val();
    return exp_lock == 1 ? 32'h1 : exp_lock == 2 ? 32'h10 : 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < WIN; i++) exp_mem[i] = '0;
    exp_mem[1]     = conf_fixed();
    exp_mem['h100] = 32'h2;
    exp_mem['h468/4] = 32'hFF;
    exp_mem['h47C/4] = 32'hFF;
    exp_mem['h450/4] = 32'h0FFF_FFFF;
    exp_lock = 0;
  endtask

  task automatic model_write(int i, logic [31:0] d);
    if (i >= NW) return;
    if (open_list(i)) begin exp_mem[i] = d; return; end
    if (exp_lock == 2) return;
    if (i == 0) begin
      exp_lock = (d == 32'hFC60_0309) ? 1 : (d == 32'hDEAD_DEAD) ? 2 : 0;
      return;
    end
    if (exp_lock != 1) return;
    if (i == 1)         exp_mem[i] = (d & 32'h0FF0_3FB0) | conf_fixed();
    else if (i == 'h18) exp_mem[i] = (d & ~32'h1) | 32'h10;
    else if (i == 'h1C) exp_mem[i] = (d | 32'h1000) & ~32'h2000;
    else                exp_mem[i] = d;
  endtask

  function automatic string tag_of(int i, string base);
    if (i >= NW)     return "R11";
    if (open_list(i)) return "R4";
    if (base == "R12" && i == 1)    return "R5";
    if (base == "R12" && i == 'h18) return "R7";
    if (base == "R12" && i == 'h1C) return "R8";
    return base;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic bus_write(int i, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'(i << 2); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(i, d);
  endtask

  task automatic bus_read(int i, string tag);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'(i << 2);
    @(negedge clk);
    req_valid = 1'b0;
    e = (i == 0) ? lock_val() : exp_mem[i];
    if (!rsp_valid) begin
      checks++; errors++;
      $display("FAIL R10: rsp_valid actual 0 expected 1 at index %0d", i);
    end else begin
      check(tag, rsp_rdata, e);
    end
  endtask

  function automatic logic [31:0] pat(int i, logic [31:0] seed);
    return (32'(i) * 32'h9E37_79B9) ^ seed;
  endfunction

  task automatic sweep_write(logic [31:0] seed);
    for (int i = 1; i < WIN; i++) bus_write(i, pat(i, seed));
  endtask

  task automatic sweep_read(string base);
    for (int i = 0; i < WIN; i++) bus_read(i, tag_of(i, base));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    // R10: no response while idle after reset
    @(negedge clk); check("R10", {31'b0, rsp_valid}, 32'h0);
    // R9 / R1 / R11: full reset sweep
    sweep_read("R9");

    // R3 / R4: soft-locked write sweep
    sweep_write(32'hA5A5_0F0F);
    sweep_read("R3");

    // R1: opening key
    bus_write(0, 32'hFC60_0309);
    bus_read(0, "R1");
    // R10: a write yields no response
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h008; req_wdata = 32'h1;
    @(negedge clk); req_valid = 1'b0; req_write = 1'b0; model_write(2, 32'h1);
    check("R10", {31'b0, rsp_valid}, 32'h0);

    // R12 / R5 / R7 / R8: open sweep
    sweep_write(32'h3C3C_C3C3);
    sweep_read("R12");
    // R5 / R6: extremes on the configuration word
    bus_write(1, 32'hFFFF_FFFF); bus_read(1, "R5");
    bus_write(1, 32'h0000_0000); bus_read(1, "R6");
    // R7 / R8 extremes
    bus_write('h18, 32'hFFFF_FFFF); bus_read('h18, "R7");
    bus_write('h18, 32'h0);         bus_read('h18, "R7");
    bus_write('h1C, 32'hFFFF_FFFF); bus_read('h1C, "R8");
    bus_write('h1C, 32'h0);         bus_read('h1C, "R8");

    // R1: near-miss key soft-locks
    bus_write(0, 32'hFC60_0308); bus_read(0, "R1");
    bus_write(5, 32'h1234_5678); bus_read(5, "R3");
    // R3: lock word still writable while soft-locked
    bus_write(0, 32'hFC60_0309); bus_read(0, "R3");
    bus_write(5, 32'h1234_5678); bus_read(5, "R12");

    // R1 / R2: seal
    bus_write(0, 32'hDEAD_DEAD); bus_read(0, "R1");
    bus_write(0, 32'hFC60_0309); bus_read(0, "R2");
    bus_write(0, 32'h0);         bus_read(0, "R2");
    sweep_write(32'h5555_AAAA);
    sweep_read("R2");

    // R9: reset leaves sealed state and restores defaults
    do_reset();
    sweep_read("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule